// File: doc/BRIEF.md
# Network Time Counter Synchronizer

Each node on a shared network keeps a 16-bit system time counter that starts counting as soon as reset is released. One node is the clock master. Every other node is a slave and aligns its counter to the master's. The block compares its own node ID with a programmed master ID to decide which role it has. A slave watches the received-packet strobe. The first packet from the master after the block is armed loads the carried time value directly into the counter.

Each later packet from the master is compared with the local count. The local counting rate is then trimmed slower, faster or left nominal, so that the local phase follows the master. The counter advances once every `TICK_DIV` base clocks at the nominal rate. The slow rate uses one clock more per tick and the fast rate one clock less.

A host on an 8-bit bus reads the counter through a two-address byte port. Reading the low byte captures the high byte at the same moment. A later read at the high address then returns a value consistent with that low byte. A stop input freezes the counter. When stop is released, the one-shot load is armed again.

Top module: `net_time_sync`

## Requirements
- R1: After reset the counter (`timeNow`) is 0. It then advances by exactly 1 every `TICK_DIV` clocks at the nominal rate and wraps modulo 2^16.
- R2: The master-ID register resets to 0 and takes `cmIdWrData` on a clock with `cmIdWr` high. `isMaster` is 1 exactly when that register equals `nodeId`.
- R3: A packet qualifies only when `pktValid` is high, the node is a slave, `stopCtl` is 0 and `pktSrcId` equals the master-ID register. Any other packet leaves the counter on its normal count.
- R4: The first qualifying packet after arming loads `pktTime` into the counter on that clock edge, restarts the tick divider, sets the nominal rate and disarms the load.
- R5: Reset, a write on `cmIdWr`, a `swReset` pulse and `stopCtl` falling from 1 to 0 each re-arm the one-shot load and return the rate to nominal. A packet in the same clock as such an event is ignored.
- R6: Every qualifying packet while disarmed leaves the counter value unchanged by the packet. It computes (local count minus `pktTime`) modulo 2^16 and reads the result as a signed 16-bit difference, so the comparison also works across wraparound.
- R7: A difference of +2 or more selects the slow rate (period `TICK_DIV`+1). A difference of -1 or less selects the fast rate (period `TICK_DIV`-1). A difference of 0 or +1 selects the nominal rate. The selected rate holds until the next comparison.
- R8: While `stopCtl` is 1 the counter and its divider hold their values, and packets neither load nor trim.
- R9: A master node counts only at the nominal rate and never loads or trims from packets, including packets whose source ID equals its own.
- R10: A read with `rdEn` high and `rdAddr`=0 returns the counter's bits 7:0 on `rdData` one clock later and latches bits 15:8 at the same time. A read with `rdAddr`=1 returns the latched byte one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nodeId | input | ID_W | This node's own ID |
| cmIdWr | input | 1 | Write strobe for the master-ID register |
| cmIdWrData | input | ID_W | Value written to the master-ID register |
| swReset | input | 1 | Software reset pulse; re-arms the load |
| stopCtl | input | 1 | 1 freezes the counter and ignores packets |
| pktValid | input | 1 | One-clock strobe for a received time packet |
| pktSrcId | input | ID_W | Source ID of the received packet |
| pktTime | input | 16 | Time value carried by the packet |
| rdEn | input | 1 | Host byte-read strobe |
| rdAddr | input | 1 | 0 = low byte (captures high), 1 = latched high byte |
| rdData | output | 8 | Registered read data |
| timeNow | output | 16 | Current counter value for outgoing time packets |
| isMaster | output | 1 | 1 when this node is the clock master |

## Verification
The bench sweeps the signed difference from -3 to +3 with the counter parked next to the 0xFFFF wrap. It measures the resulting tick period for each case. A design that compared without sign, or that placed the dead band symmetrically, would get the period wrong at -1, +1 or across the wrap. The bench also hits each re-arm source, including a packet that arrives in the same clock as a software reset. A design that missed one of these would trim instead of loading, or would load from the colliding packet. Further cases cover packets from the wrong source, packets while stopped, a master that hears its own ID, and a high-byte read made after the counter has jumped. Each of these exposes a stray load or a torn read.

// File: rtl/nts_pkg.sv
package nts_pkg;
  typedef enum logic [1:0] {
    RATE_NOM  = 2'd0,
    RATE_SLOW = 2'd1,
    RATE_FAST = 2'd2
  } rate_e;

  typedef struct packed {
    logic  load;
    logic  hold;
    rate_e rate;
  } ctrl_s;
endpackage

// File: rtl/nts_ctrl.sv
module nts_ctrl
  import nts_pkg::*;
#(
  parameter int ID_W   = 8,
  parameter int TIME_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   nodeId,
  input  logic              cmIdWr,
  input  logic [ID_W-1:0]   cmIdWrData,
  input  logic              swReset,
  input  logic              stopCtl,
  input  logic              pktValid,
  input  logic [ID_W-1:0]   pktSrcId,
  input  logic [TIME_W-1:0] pktTime,
  input  logic [TIME_W-1:0] timeNow,
  output logic              isMaster,
  output ctrl_s             ctrl
);
  logic [ID_W-1:0] cmIdReg;
  logic            stopPrev;
  logic            armed;
  rate_e           rateMode;
  logic            rearm;
  logic            qualify;
  logic signed [TIME_W-1:0] diff;
  rate_e           zoneRate;

  assign isMaster = (cmIdReg == nodeId);
  assign rearm    = cmIdWr | swReset | (stopPrev & ~stopCtl);
  assign qualify  = pktValid & ~stopCtl & ~isMaster &
                    (pktSrcId == cmIdReg) & ~rearm;
  assign diff     = signed'(timeNow - pktTime);

  always_comb begin
    if (diff >= 2)       zoneRate = RATE_SLOW;
    else if (diff <= -1) zoneRate = RATE_FAST;
    else                 zoneRate = RATE_NOM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmIdReg  <= '0;
      stopPrev <= 1'b0;
      armed    <= 1'b1;
      rateMode <= RATE_NOM;
    end else begin
      stopPrev <= stopCtl;
      if (cmIdWr) cmIdReg <= cmIdWrData;
      if (rearm) begin
        armed    <= 1'b1;
        rateMode <= RATE_NOM;
      end else if (qualify) begin
        if (armed) begin
          armed    <= 1'b0;
          rateMode <= RATE_NOM;
        end else begin
          rateMode <= zoneRate;
        end
      end
    end
  end

  always_comb begin
    ctrl.load = qualify & armed;
    ctrl.hold = stopCtl;
    ctrl.rate = isMaster ? RATE_NOM : rateMode;
  end
endmodule

// File: rtl/nts_datapath.sv
module nts_datapath
  import nts_pkg::*;
#(
  parameter int TIME_W   = 16,
  parameter int TICK_DIV = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrl_s             ctrl,
  input  logic [TIME_W-1:0] pktTime,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [TIME_W-1:0] timeNow,
  output logic [7:0]        rdData
);
  localparam int DIV_W = $clog2(TICK_DIV + 2);
  localparam logic [DIV_W-1:0] LAST_NOM  = DIV_W'(TICK_DIV - 1);
  localparam logic [DIV_W-1:0] LAST_SLOW = DIV_W'(TICK_DIV);
  localparam logic [DIV_W-1:0] LAST_FAST = DIV_W'(TICK_DIV - 2);

  logic [DIV_W-1:0]  divCnt;
  logic [DIV_W-1:0]  lastCnt;
  logic [TIME_W-1:0] cnt;
  logic [7:0]        hiLatch;

  always_comb begin
    unique case (ctrl.rate)
      RATE_SLOW: lastCnt = LAST_SLOW;
      RATE_FAST: lastCnt = LAST_FAST;
      default:   lastCnt = LAST_NOM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      divCnt <= '0;
    end else if (ctrl.load) begin
      cnt    <= pktTime;
      divCnt <= '0;
    end else if (!ctrl.hold) begin
      if (divCnt >= lastCnt) begin
        divCnt <= '0;
        cnt    <= cnt + 1'b1;
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData  <= '0;
      hiLatch <= '0;
    end else if (rdEn) begin
      if (!rdAddr) begin
        rdData  <= cnt[7:0];
        hiLatch <= cnt[15:8];
      end else begin
        rdData  <= hiLatch;
      end
    end
  end

  assign timeNow = cnt;
endmodule

// File: rtl/net_time_sync.sv
module net_time_sync
  import nts_pkg::*;
#(
  parameter int ID_W     = 8,
  parameter int TICK_DIV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] nodeId,
  input  logic            cmIdWr,
  input  logic [ID_W-1:0] cmIdWrData,
  input  logic            swReset,
  input  logic            stopCtl,
  input  logic            pktValid,
  input  logic [ID_W-1:0] pktSrcId,
  input  logic [15:0]     pktTime,
  input  logic            rdEn,
  input  logic            rdAddr,
  output logic [7:0]      rdData,
  output logic [15:0]     timeNow,
  output logic            isMaster
);
  localparam int TIME_W = 16;
  ctrl_s ctrl;

  nts_ctrl #(.ID_W(ID_W), .TIME_W(TIME_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .nodeId(nodeId), .cmIdWr(cmIdWr),
    .cmIdWrData(cmIdWrData), .swReset(swReset), .stopCtl(stopCtl),
    .pktValid(pktValid), .pktSrcId(pktSrcId), .pktTime(pktTime),
    .timeNow(timeNow), .isMaster(isMaster), .ctrl(ctrl)
  );

  nts_datapath #(.TIME_W(TIME_W), .TICK_DIV(TICK_DIV)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .pktTime(pktTime),
    .rdEn(rdEn), .rdAddr(rdAddr), .timeNow(timeNow), .rdData(rdData)
  );
endmodule

// File: rtl/nts_checker.sv
module nts_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        stopCtl,
  input logic        pktValid,
  input logic        swReset,
  input logic        isMaster,
  input logic        rdEn,
  input logic        rdAddr,
  input logic [7:0]  rdData,
  input logic [15:0] timeNow
);
  p_hold_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stopCtl |=> $stable(timeNow));

  p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pktValid |=> (timeNow == $past(timeNow) || timeNow == 16'($past(timeNow) + 16'd1)));

  p_master_noload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    isMaster |=> (timeNow == $past(timeNow) || timeNow == 16'($past(timeNow) + 16'd1)));

  p_rearm_noload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    swReset |=> (timeNow == $past(timeNow) || timeNow == 16'($past(timeNow) + 16'd1)));

  p_rd_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && !rdAddr) |=> rdData == $past(timeNow[7:0]));
endmodule

bind net_time_sync nts_checker u_chk (
  .clk(clk), .rst_n(rst_n), .stopCtl(stopCtl), .pktValid(pktValid),
  .swReset(swReset), .isMaster(isMaster), .rdEn(rdEn), .rdAddr(rdAddr),
  .rdData(rdData), .timeNow(timeNow)
);

// File: tb/net_time_sync_bench.sv
module net_time_sync_bench;
  localparam int N = 4;
  localparam logic [7:0] MY_ID = 8'd5;
  localparam logic [7:0] CM_ID = 8'd3;

  logic clk = 0, rst_n = 0;
  logic [7:0] nodeId = MY_ID, cmIdWrData = '0, pktSrcId = '0;
  logic cmIdWr = 0, swReset = 0, stopCtl = 0, pktValid = 0, rdEn = 0, rdAddr = 0;
  logic [15:0] pktTime = '0;
  logic [7:0] rdData;
  logic [15:0] timeNow;
  logic isMaster;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  net_time_sync #(.ID_W(8), .TICK_DIV(N)) u_net_time_sync (
    .clk(clk), .rst_n(rst_n), .nodeId(nodeId), .cmIdWr(cmIdWr),
    .cmIdWrData(cmIdWrData), .swReset(swReset), .stopCtl(stopCtl),
    .pktValid(pktValid), .pktSrcId(pktSrcId), .pktTime(pktTime),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .timeNow(timeNow),
    .isMaster(isMaster)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic sendPkt(input logic [7:0] src, input logic [15:0] t,
                         input bit sw = 0, input bit wr = 0);
    pktValid = 1; pktSrcId = src; pktTime = t; swReset = sw;
    cmIdWr = wr; cmIdWrData = CM_ID;
    @(negedge clk);
    pktValid = 0; swReset = 0; cmIdWr = 0;
  endtask

  task automatic writeCm(input logic [7:0] v);
    cmIdWr = 1; cmIdWrData = v;
    @(negedge clk);
    cmIdWr = 0;
  endtask

  task automatic pulseSw();
    swReset = 1; @(negedge clk); swReset = 0;
  endtask

  task automatic measure(output int p);
    logic [15:0] v;
    int n;
    v = timeNow; n = 0;
    while (timeNow == v && n < 100) begin @(negedge clk); n++; end
    v = timeNow; n = 0;
    while (timeNow == v && n < 100) begin @(negedge clk); n++; end
    p = n;
  endtask

  task automatic readByte(input bit a, output logic [7:0] d);
    rdEn = 1; rdAddr = a;
    @(negedge clk);
    rdEn = 0;
    d = rdData;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      nBad++; nChk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end

  initial begin
    int p, expP;
    logic [15:0] v, prev;
    logic [7:0] b;

    @(negedge clk); @(negedge clk);
    chk(timeNow == 0, "R1 reset count", timeNow, 0);
    chk(rdData == 0, "R10 reset rdData", rdData, 0);
    chk(isMaster == 0, "R2 reset master id 0 vs node 5", isMaster, 0);
    rst_n = 1;
    @(negedge clk);
    measure(p);
    chk(p == N, "R1 free-run period", p, N);

    writeCm(CM_ID);
    chk(isMaster == 0, "R2 slave after write", isMaster, 0);

    // R3: wrong source is ignored
    prev = timeNow;
    sendPkt(8'd7, 16'h4000);
    chk(timeNow == prev || timeNow == prev + 1, "R3 wrong source ignored", timeNow, prev);

    // R4: first qualifying packet presets
    sendPkt(CM_ID, 16'h1234);
    chk(timeNow == 16'h1234, "R4 preset", timeNow, 16'h1234);

    // R6: later packet does not load; diff negative -> fast
    prev = timeNow;
    sendPkt(CM_ID, 16'h8000);
    chk(timeNow == prev || timeNow == prev + 1, "R6 no second load", timeNow, prev);
    measure(p);
    chk(p == N - 1, "R7 fast after negative diff", p, N - 1);

    // R7 sweep across the wrap point, R5 re-arm by swReset
    for (int d = -3; d <= 3; d++) begin
      pulseSw();
      sendPkt(CM_ID, 16'hFFFE);
      chk(timeNow == 16'hFFFE, "R5 swReset re-arms preset", timeNow, 16'hFFFE);
      v = timeNow;
      sendPkt(CM_ID, 16'(v - 16'(d)));
      measure(p);
      expP = (d >= 2) ? N + 1 : (d <= -1) ? N - 1 : N;
      chk(p == expP, $sformatf("R7 zone diff=%0d", d), p, expP);
    end

    // R5 re-arm via master-ID write of the same value
    writeCm(CM_ID);
    sendPkt(CM_ID, 16'h2222);
    chk(timeNow == 16'h2222, "R5 cmIdWr re-arms", timeNow, 16'h2222);

    // R5 collision: packet with swReset in same clock ignored
    prev = timeNow;
    sendPkt(CM_ID, 16'h3333, 1'b1);
    chk(timeNow == prev || timeNow == prev + 1, "R5 colliding packet ignored", timeNow, prev);
    sendPkt(CM_ID, 16'h3456);
    chk(timeNow == 16'h3456, "R5 preset after collision", timeNow, 16'h3456);

    // R8: stop holds and ignores packets
    stopCtl = 1;
    @(negedge clk);
    v = timeNow;
    repeat (3 * N) @(negedge clk);
    chk(timeNow == v, "R8 hold while stopped", timeNow, v);
    writeCm(CM_ID);
    sendPkt(CM_ID, 16'h5A5A);
    chk(timeNow == v, "R8 packet ignored while stopped", timeNow, v);

    // R10 coherent read: low read latches high; counter then jumps
    readByte(1'b0, b);
    chk(b == v[7:0], "R10 low byte", b, v[7:0]);
    stopCtl = 0;
    @(negedge clk);
    sendPkt(CM_ID, 16'hAB00);
    chk(timeNow == 16'hAB00, "R5 stop release re-arms", timeNow, 16'hAB00);
    readByte(1'b1, b);
    chk(b == v[15:8], "R10 latched high byte", b, v[15:8]);

    // R9 master: no load, nominal rate
    sendPkt(CM_ID, 16'h0000);
    writeCm(MY_ID);
    chk(isMaster == 1, "R2 master when ids equal", isMaster, 1);
    prev = timeNow;
    sendPkt(MY_ID, 16'h5555);
    chk(timeNow == prev || timeNow == prev + 1, "R9 master ignores packet", timeNow, prev);
    measure(p);
    chk(p == N, "R9 master nominal rate", p, N);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule